// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog with a two-step expiry. Software sets one 8-bit control and status word, which holds the enables, the flags, a restart strobe and a clock-select field. While the watchdog is enabled, a down-counter moves one step on each cycle where the `tick` reference enable is high. Its starting value is the base timeout scaled by a prescaler that the clock-select field picks.

When the counter runs out the first time, the block sets an interrupt flag and reloads a short grace count, scaled by the same prescaler, and the count continues on its own. If software does not service the interrupt before the grace count also runs out, the block sets a sticky reset flag and gives a one-cycle reset request, provided reset is enabled. A core-domain reset puts the control word back to its default and stops the count. It keeps the reset flag, so software can see after the restart that the watchdog caused the reset. Only the asynchronous power-on reset or a write of 1 clears that flag.

Bit map of the control word:

| Bit | Name | Access | Meaning |
|---|---|---|---|
| 0 | restart | write | Writing 1 restarts the full timeout. Always reads 0. |
| 1 | reset flag | write 1 to clear | Set by the second expiry. |
| 2 | reset enable | read/write | Allows the second expiry to act. |
| 3 | interrupt flag | write 1 to clear | Set by the first expiry. |
| 4 | interrupt enable | read/write | Lets the flag drive `irq`. |
| 5 | enable | read/write | Counting runs only while set. |
| 7:6 | clock select | read/write | Picks the prescaler 2^(sel·PSC_STEP). |

Top module: `wdog_two_stage`

## Requirements
- R1: After the power-on reset (`rst_n` low), `rd_data` reads 0x40 (clock select = 1, every other bit 0), and `irq` and `rst_req` are both 0.
- R2: While the enable bit (bit 5) is 0, the counter holds its value. No expiry takes place, so no flag is set and neither `irq` nor `rst_req` is asserted.
- R3: Setting the enable bit from 0 to 1 loads BASE_CYCLES·2^(sel·PSC_STEP). The interrupt flag (bit 3) sets on the clock edge of the tick that brings the count to zero, which is the last counted tick of that timeout. `irq` is high exactly while bit 3 and the interrupt enable (bit 4) are both 1.
- R4: After the first expiry, the counter reloads GRACE_CYCLES·2^(sel·PSC_STEP) and keeps counting. If the reset enable (bit 2) is 1 when that count runs out, the reset flag (bit 1) sets and `rst_req` is high for exactly one cycle, the cycle after that edge.
- R5: If the reset enable is 0 when the grace count runs out, nothing changes and the counter stays stopped.
- R6: The clock-select field (bits 7:6) sets the length of both stages through the prescaler 2^(sel·PSC_STEP). A new value takes effect at the next reload.
- R7: A core-domain reset (`core_rst` high at a clock edge) sets the word to 0x40 with bit 1 kept at its old value, and stops the counter.
- R8: The reset flag clears only on the power-on reset or on a write with bit 1 set. A core-domain reset leaves it unchanged.
- R9: A write with bit 3 set while the interrupt flag is set clears the flag, drops `irq`, and reloads the full timeout. The block is back in the first stage.
- R10: A write with bit 0 set clears the interrupt flag and reloads the full timeout. Bit 0 always reads 0.
- R11: The counter does not count a tick that comes in a cycle with `wr_en` high. It counts only cycles where `tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| core_rst | input | 1 | Synchronous core-domain reset, active high |
| tick | input | 1 | Reference-cycle enable for the counter |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 8 | Write data for the control word |
| rd_data | output | 8 | Current control and status word |
| irq | output | 1 | Interrupt level |
| rst_req | output | 1 | One-cycle reset request |

## Verification
A wrong count or a stage bit out of step with the counter has one visible effect: a flag bit in `rd_data` rises on the wrong tick. Every stage is therefore measured by the exact number of counted ticks up to the edge where its flag changes, at several clock-select values. A sticky-flag or write-decode fault appears in `rd_data` on the cycle after the write or the core reset. A reset pulse of the wrong length or in the wrong cycle is caught by comparing `rst_req` and `irq` with a reference model on every clock.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int REG_W      = 8;
  localparam int B_RESTART  = 0;
  localparam int B_RST_FLAG = 1;
  localparam int B_RST_EN   = 2;
  localparam int B_IRQ_FLAG = 3;
  localparam int B_IRQ_EN   = 4;
  localparam int B_ENABLE   = 5;
  localparam int B_SEL_LO   = 6;
  localparam logic [1:0] SEL_DEFAULT = 2'd1;

  typedef struct packed {
    logic [1:0] sel;
    logic       en;
    logic       ie;
    logic       irq_f;
    logic       re;
    logic       rst_f;
  } ctrl_t;
endpackage

// File: rtl/wdog_timeout_lut.sv
module wdog_timeout_lut #(
  parameter int BASE_CYCLES  = 16,
  parameter int GRACE_CYCLES = 4,
  parameter int PSC_STEP     = 1,
  parameter int CNT_W        = 8
) (
  input  logic [1:0]       sel,
  input  logic             grace,
  output logic [CNT_W-1:0] val
);
  localparam int NSEL = 4;

  logic [CNT_W-1:0] full_tab  [NSEL];
  logic [CNT_W-1:0] grace_tab [NSEL];

  for (genvar s = 0; s < NSEL; s++) begin : g_tab
    assign full_tab[s]  = CNT_W'(BASE_CYCLES)  << (s * PSC_STEP);
    assign grace_tab[s] = CNT_W'(GRACE_CYCLES) << (s * PSC_STEP);
  end

  assign val = grace ? grace_tab[sel] : full_tab[sel];
endmodule

// File: rtl/wdog_downcnt.sv
module wdog_downcnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             step;

  always_comb begin
    step   = tick & run & (cnt_q != '0);
    expire = step & (cnt_q == CNT_W'(1));
    cnt_d  = cnt_q;
    if (load)      cnt_d = load_val;
    else if (step) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             core_rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             expire,
  input  logic [CNT_W-1:0] lut_val,
  output ctrl_t            ctrl,
  output logic [1:0]       lut_sel,
  output logic             lut_grace,
  output logic             run,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic             rst_req
);
  ctrl_t ctrl_q, ctrl_d;
  logic  req_q, req_d;
  logic  restart_w, starting, clr_irq;

  always_comb begin
    ctrl_d    = ctrl_q;
    req_d     = 1'b0;
    load      = 1'b0;
    lut_sel   = ctrl_q.sel;
    lut_grace = 1'b0;
    restart_w = wr_data[B_RESTART];
    starting  = wr_data[B_ENABLE] & ~ctrl_q.en;
    clr_irq   = wr_data[B_IRQ_FLAG] & ctrl_q.irq_f;
    if (core_rst) begin
      ctrl_d       = '0;
      ctrl_d.sel   = SEL_DEFAULT;
      ctrl_d.rst_f = ctrl_q.rst_f;
      load         = 1'b1;
    end else if (wr_en) begin
      ctrl_d.sel   = wr_data[B_SEL_LO +: 2];
      ctrl_d.en    = wr_data[B_ENABLE];
      ctrl_d.ie    = wr_data[B_IRQ_EN];
      ctrl_d.re    = wr_data[B_RST_EN];
      ctrl_d.irq_f = ctrl_q.irq_f & ~wr_data[B_IRQ_FLAG] & ~restart_w;
      ctrl_d.rst_f = ctrl_q.rst_f & ~wr_data[B_RST_FLAG];
      lut_sel      = wr_data[B_SEL_LO +: 2];
      load         = restart_w | starting | clr_irq;
    end else if (expire) begin
      if (!ctrl_q.irq_f) begin
        ctrl_d.irq_f = 1'b1;
        lut_grace    = 1'b1;
        load         = 1'b1;
      end else if (ctrl_q.re) begin
        ctrl_d.rst_f = 1'b1;
        req_d        = 1'b1;
      end
    end
    load_val = core_rst ? '0 : lut_val;
    run      = ctrl_q.en & ~wr_en & ~core_rst;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      ctrl_q.sel <= SEL_DEFAULT;
      req_q      <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      req_q  <= req_d;
    end
  end

  assign ctrl    = ctrl_q;
  assign rst_req = req_q;
endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
  import wdog_pkg::*;
#(
  parameter int BASE_CYCLES  = 16,
  parameter int GRACE_CYCLES = 4,
  parameter int PSC_STEP     = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             core_rst,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             irq,
  output logic             rst_req
);
  localparam int MAX_CYC = (BASE_CYCLES > GRACE_CYCLES) ? BASE_CYCLES : GRACE_CYCLES;
  localparam int CNT_W   = $clog2((MAX_CYC << (3 * PSC_STEP)) + 1);

  ctrl_t            ctrl;
  logic [1:0]       lut_sel;
  logic             lut_grace, run, load, expire;
  logic [CNT_W-1:0] lut_val, load_val, cnt_q;

  wdog_timeout_lut #(
    .BASE_CYCLES(BASE_CYCLES), .GRACE_CYCLES(GRACE_CYCLES),
    .PSC_STEP(PSC_STEP), .CNT_W(CNT_W)
  ) u_lut (
    .sel(lut_sel), .grace(lut_grace), .val(lut_val)
  );

  wdog_downcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .load(load),
    .load_val(load_val), .expire(expire), .count(cnt_q)
  );

  wdog_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .core_rst(core_rst), .wr_en(wr_en),
    .wr_data(wr_data), .expire(expire), .lut_val(lut_val), .ctrl(ctrl),
    .lut_sel(lut_sel), .lut_grace(lut_grace), .run(run), .load(load),
    .load_val(load_val), .rst_req(rst_req)
  );

  assign rd_data = {ctrl, 1'b0};
  assign irq     = ctrl.irq_f & ctrl.ie;
endmodule

// File: rtl/wdog_two_stage_chk.sv
module wdog_two_stage_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             core_rst,
  input logic             wr_en,
  input logic [7:0]       wr_data,
  input logic [7:0]       rd_data,
  input logic             irq,
  input logic             rst_req,
  input logic [CNT_W-1:0] cnt_q
);
  AST_RSTREQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req); // R4

  AST_RSTREQ_AFTER_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (rd_data[1] && $past(rd_data[3]) && $past(rd_data[2]))); // R4

  AST_CORE_RST_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |=> (((rd_data & 8'hFD) == 8'h40) && (rd_data[1] == $past(rd_data[1])))); // R7

  AST_RESTART_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[0]); // R10

  AST_HOLD_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_data[5] && !wr_en && !core_rst) |=> $stable(cnt_q)); // R2

  AST_IRQ_FLAG_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[3]) |-> $past(rd_data[5])); // R2

  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (rd_data[3] && rd_data[4])); // R3

  AST_RST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_data[1]) |-> $past(wr_en && wr_data[1] && !core_rst)); // R8
endmodule

bind wdog_two_stage wdog_two_stage_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .core_rst(core_rst), .wr_en(wr_en),
  .wr_data(wr_data), .rd_data(rd_data), .irq(irq), .rst_req(rst_req),
  .cnt_q(cnt_q)
);

// File: tb/sim_wdog_two_stage.sv
`timescale 1ns/1ps
module sim_wdog_two_stage;
  localparam int BASE  = 16;
  localparam int GRACE = 4;
  localparam int STEP  = 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       core_rst = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       irq, rst_req;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  bit live = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  wdog_two_stage #(.BASE_CYCLES(BASE), .GRACE_CYCLES(GRACE), .PSC_STEP(STEP)) u0 (
    .clk(clk), .rst_n(rst_n), .core_rst(core_rst), .tick(tick),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .irq(irq),
    .rst_req(rst_req)
  );

  // behavioural reference model
  int m_sel = 1, m_cnt = 0;
  bit m_en = 0, m_ie = 0, m_re = 0, m_if = 0, m_rf = 0, m_req = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sel = 1; m_en = 0; m_ie = 0; m_re = 0; m_if = 0; m_rf = 0;
      m_cnt = 0; m_req = 0;
    end else begin
      m_req = 0;
      if (core_rst) begin
        m_sel = 1; m_en = 0; m_ie = 0; m_re = 0; m_if = 0; m_cnt = 0;
      end else if (wr_en) begin
        bit reload;
        reload = wr_data[0] || (wr_data[5] && !m_en) || (wr_data[3] && m_if);
        m_sel = int'(wr_data[7:6]);
        m_en = wr_data[5]; m_ie = wr_data[4]; m_re = wr_data[2];
        if (wr_data[3] || wr_data[0]) m_if = 0;
        if (wr_data[1]) m_rf = 0;
        if (reload) m_cnt = BASE * (1 << (m_sel * STEP));
      end else if (tick && m_en && m_cnt > 0) begin
        if (m_cnt > 1) m_cnt = m_cnt - 1;
        else begin
          m_cnt = 0;
          if (!m_if) begin
            m_if = 1;
            m_cnt = GRACE * (1 << (m_sel * STEP));
          end else if (m_re) begin
            m_rf = 1; m_req = 1;
          end
        end
      end
    end
  end

  function automatic logic [7:0] m_word();
    return {m_sel[1:0], m_en, m_ie, m_if, m_re, m_rf, 1'b0};
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (live && !done) begin
      check(rd_data == m_word(), "R1 word vs model", rd_data, m_word());
      check(irq == (m_if && m_ie), "R3 irq vs model", irq, m_if && m_ie);
      check(rst_req == m_req, "R4 rst_req vs model", rst_req, m_req);
    end
  end

  task automatic run_ticks(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual=%0d expected<100000 cycles", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    live = 1'b1;
    // R1
    check(rd_data == 8'h40, "R1 reset word", rd_data, 8'h40);
    check(irq == 0 && rst_req == 0, "R1 outputs idle", {irq, rst_req}, 0);

    // R2: disabled, ticks have no effect
    run_ticks(100);
    check(rd_data == 8'h40 && !irq, "R2 disabled no expiry", rd_data, 8'h40);

    // R3: sel 0, en+ie+re -> timeout 16
    wr(8'h34);
    run_ticks(BASE - 1);
    check(rd_data[3] == 0, "R3 flag before timeout", rd_data[3], 0);
    run_ticks(1);
    check(rd_data[3] == 1 && irq == 1, "R3 flag at timeout", {rd_data[3], irq}, 3);

    // R4: grace of 4 then reset pulse
    run_ticks(GRACE - 1);
    check(rd_data[1] == 0 && rst_req == 0, "R4 before grace end", {rd_data[1], rst_req}, 0);
    run_ticks(1);
    check(rd_data[1] == 1 && rst_req == 1, "R4 reset pulse", {rd_data[1], rst_req}, 3);
    @(negedge clk);
    check(rst_req == 0, "R4 pulse one cycle", rst_req, 0);

    // R9: clear irq flag -> irq drops, full reload
    wr(8'h3C);
    check(rd_data == 8'h36 && !irq, "R9 flag cleared", rd_data, 8'h36);
    // R8: clear reset flag by write
    wr(8'h36);
    check(rd_data[1] == 0, "R8 W1C reset flag", rd_data[1], 0);
    run_ticks(BASE - 1);
    check(rd_data[3] == 0, "R9 full reload not yet", rd_data[3], 0);
    run_ticks(1);
    check(rd_data[3] == 1, "R9 full reload expiry", rd_data[3], 1);

    // R10: restart clears flag and reloads full timeout
    wr(8'h35);
    check(rd_data == 8'h34, "R10 restart clears flag, reads 0", rd_data, 8'h34);
    run_ticks(10);
    wr(8'h35);
    run_ticks(BASE - 1);
    check(rd_data[3] == 0, "R10 restart reloaded", rd_data[3], 0);
    run_ticks(1);
    check(rd_data[3] == 1, "R10 restart expiry", rd_data[3], 1);

    // R5: reset enable off, grace ends with no effect
    wr(8'h30);
    run_ticks(GRACE + 20);
    check(rd_data == 8'h38 && !rst_req, "R5 no reset without enable", rd_data, 8'h38);

    // R6: sel 2 -> timeout 64, grace 16
    wr(8'hB8);
    run_ticks(BASE * 4 - 1);
    check(rd_data[3] == 0, "R6 sel2 before timeout", rd_data[3], 0);
    run_ticks(1);
    check(rd_data[3] == 1, "R6 sel2 timeout", rd_data[3], 1);
    wr(8'hB4);
    run_ticks(GRACE * 4 - 1);
    check(rd_data[1] == 0, "R6 sel2 grace not yet", rd_data[1], 0);
    run_ticks(1);
    check(rd_data[1] == 1 && rst_req, "R6 sel2 grace end", {rd_data[1], rst_req}, 3);

    // R11: a tick during a write is not counted
    wr(8'hB1);
    run_ticks(60);
    tick = 1'b1;
    wr(8'hB0);
    tick = 1'b0;
    run_ticks(3);
    check(rd_data[3] == 0, "R11 write-cycle tick ignored", rd_data[3], 0);
    run_ticks(1);
    check(rd_data[3] == 1, "R11 expiry after 64 counted", rd_data[3], 1);

    // R7: core reset keeps reset flag
    core_rst = 1'b1;
    @(negedge clk);
    core_rst = 1'b0;
    check(rd_data == 8'h42 && !irq, "R7 core reset word", rd_data, 8'h42);
    run_ticks(200);
    check(rd_data == 8'h42, "R7 counting stopped", rd_data, 8'h42);

    // R8: power-on reset clears the reset flag
    live = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    live = 1'b1;
    check(rd_data == 8'h40, "R8 power-on clears flag", rd_data, 8'h40);
    @(negedge clk);
    finish_run();
  end
endmodule